// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a memory burst. A command pulse loads a start column, a burst-length code and an ordering choice. From the following cycle the block presents one column per clock, together with a valid strobe and a flag that marks the final beat. Two orderings are available. In the linear ordering the column counts upward and wraps inside the aligned block whose size is the burst length. In the interleaved ordering the low column bits are the start bits XOR-ed with the beat number.

A page-length setting makes the linear ordering run through the whole 1024-column space. It wraps from the top column to column zero and never flags a final beat, so it ends only when a stop or a new command arrives. A stop pulse ends any burst at once. A new command may arrive on any cycle, including during a burst, and the sequence restarts from the new start column. When both arrive together, the command wins.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `valid_o` and `last_o` are 0 until the first command.
- R2: In the cycle after `start_i` is sampled high, `valid_o` is 1 and `col_o` equals the sampled `col_start_i`.
- R3: `len_i` codes map to burst lengths: 0 → 1 beat, 1 → 2, 2 → 4, 3 → 8, 7 → page. The unused codes 4, 5 and 6 act as 1 beat.
- R4: In linear ordering (`ilv_i`=0), beat k carries low log2(BL) bits equal to (start low bits + k) mod BL.
- R5: In interleaved ordering (`ilv_i`=1), beat k carries low log2(BL) bits equal to start low bits XOR k.
- R6: `last_o` is 1 on beat BL−1 only, and `valid_o` is 0 in the cycle after that beat unless a new command was sampled.
- R7: Page length with linear ordering steps through all 1024 columns, going from 1023 to 0, and never raises `last_o`.
- R8: Code 7 with interleaved ordering runs as an 8-beat interleaved burst.
- R9: A `stop_i` pulse with `start_i` low makes `valid_o` 0 in the next cycle, and it stays 0 until the next command.
- R10: A command sampled during a burst restarts the sequence from the new start. If `start_i` and `stop_i` arrive together, the command wins.
- R11: In fixed-length bursts, the column bits above log2(BL) keep the start value on every beat.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Command pulse that loads a new burst |
| col_start_i | input | 10 | Start column for the new burst |
| len_i | input | 3 | Burst-length code (see R3) |
| ilv_i | input | 1 | 1 selects interleaved ordering |
| stop_i | input | 1 | Ends the current burst |
| valid_o | output | 1 | A column is presented this cycle |
| col_o | output | 10 | Column for the current beat |
| last_o | output | 1 | The current beat is the final one |

## Verification
A corrupted beat counter or length mask shows up on `col_o` on the very next beat. It gives a wrong low-bit pattern, or it lets the column leave its aligned block. A wrong length decode moves `last_o`, or leaves `valid_o` high for one beat too many, within at most eight cycles of the command. An active flag that fails to clear after a stop is seen one cycle after the stop, because the next column is then still flagged valid. The bench therefore compares every beat of every burst against a column model. For page mode it checks across the top-column wrap.

// File: rtl/burst_pkg.sv
package burst_pkg;

    // Burst-length codes presented on len_i
    typedef enum logic [2:0] {
        BL_ONE   = 3'd0,
        BL_TWO   = 3'd1,
        BL_FOUR  = 3'd2,
        BL_EIGHT = 3'd3,
        BL_PAGE  = 3'd7
    } blen_code_e;

    // Largest fixed burst is 8 beats: 3 low bits may move
    localparam int unsigned MAX_FIXED_LOG2 = 3;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
    import burst_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic [2:0]       len_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] mask_o,
    output logic             full_o
);

    localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};
    localparam logic [COL_W-1:0] MASK_8   = ~(ALL_ONES << MAX_FIXED_LOG2);

    always_comb begin
        mask_o = '0;
        full_o = 1'b0;
        unique case (len_i)
            BL_ONE, BL_TWO, BL_FOUR, BL_EIGHT: begin
                mask_o = ~(ALL_ONES << len_i[1:0]);
            end
            BL_PAGE: begin
                // page length is only legal for linear ordering
                if (ilv_i) begin
                    mask_o = MASK_8;
                end else begin
                    mask_o = ALL_ONES;
                    full_o = 1'b1;
                end
            end
            default: begin
                mask_o = '0;   // reserved codes behave as a single beat
            end
        endcase
    end

endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc #(
    parameter int unsigned COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] lin_sum;
    logic [COL_W-1:0] ilv_mix;
    logic [COL_W-1:0] moved;

    assign lin_sum = base_i + beat_i;
    assign ilv_mix = base_i ^ beat_i;

    // per bit: bits inside the mask move, bits above it hold the start value
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign moved[b] = ilv_i ? ilv_mix[b] : lin_sum[b];
        assign col_o[b] = mask_i[b] ? moved[b] : base_i[b];
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] col_start_i,
    input  logic [2:0]       len_i,
    input  logic             ilv_i,
    input  logic             stop_i,
    output logic             valid_o,
    output logic [COL_W-1:0] col_o,
    output logic             last_o
);

    localparam int unsigned HOLD_LSB = MAX_FIXED_LOG2;

    typedef struct packed {
        logic             active;
        logic             ilv;
        logic             full;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] mask;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [COL_W-1:0] new_mask;
    logic             new_full;
    logic [COL_W-1:0] cur_col;
    logic             at_end;

    burst_len_decode #(.COL_W(COL_W)) u_dec (
        .len_i  (len_i),
        .ilv_i  (ilv_i),
        .mask_o (new_mask),
        .full_o (new_full)
    );

    burst_addr_calc #(.COL_W(COL_W)) u_calc (
        .base_i (st_q.base),
        .beat_i (st_q.beat),
        .mask_i (st_q.mask),
        .ilv_i  (st_q.ilv),
        .col_o  (cur_col)
    );

    assign at_end = st_q.active && !st_q.full && (st_q.beat == st_q.mask);

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.ilv    = ilv_i && !new_full;
            st_d.full   = new_full;
            st_d.base   = col_start_i;
            st_d.beat   = '0;
            st_d.mask   = new_mask;
        end else if (stop_i) begin
            st_d.active = 1'b0;
            st_d.beat   = '0;
        end else if (st_q.active) begin
            if (at_end) begin
                st_d.active = 1'b0;
                st_d.beat   = '0;
            end else begin
                st_d.beat = st_q.beat + 1'b1;   // page mode wraps naturally
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.active;
    assign col_o   = cur_col;
    assign last_o  = at_end;

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o); // R6

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(col_start_i))); // R2

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !valid_o); // R9

    AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && st_q.full) |-> !last_o); // R7

    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !st_q.full && !last_o && !start_i && !stop_i)
        |=> (col_o[COL_W-1:HOLD_LSB] == $past(col_o[COL_W-1:HOLD_LSB]))); // R11

    AST_END_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o); // R6

endmodule

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic [9:0] col_start_i;
    logic [2:0] len_i;
    logic       ilv_i;
    logic       stop_i;
    logic       valid_o;
    logic [9:0] col_o;
    logic       last_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    burst_col_gen dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_start_i(col_start_i),
        .len_i(len_i), .ilv_i(ilv_i), .stop_i(stop_i),
        .valid_o(valid_o), .col_o(col_o), .last_o(last_o)
    );

    typedef struct packed {
        logic [9:0]  s;
        logic [2:0]  len;
        logic        ilv;
        logic [10:0] bl;
        logic        mix;     // ordering the model uses
        logic [9:0]  lastc;
    } vec_t;

    // start, code, ilv, beats, model ordering, expected final column
    localparam vec_t VEC [10] = '{
        '{10'h005, 3'd0, 1'b0, 11'd1, 1'b0, 10'h005},  // R3 single
        '{10'h00D, 3'd1, 1'b0, 11'd2, 1'b0, 10'h00C},  // R4
        '{10'h0A6, 3'd2, 1'b0, 11'd4, 1'b0, 10'h0A5},  // R4
        '{10'h2FD, 3'd3, 1'b0, 11'd8, 1'b0, 10'h2FC},  // R4 R11
        '{10'h0A6, 3'd2, 1'b1, 11'd4, 1'b1, 10'h0A5},  // R5
        '{10'h113, 3'd3, 1'b1, 11'd8, 1'b1, 10'h114},  // R5
        '{10'h3FF, 3'd3, 1'b1, 11'd8, 1'b1, 10'h3F8},  // R5 R11
        '{10'h07B, 3'd7, 1'b1, 11'd8, 1'b1, 10'h07C},  // R8
        '{10'h042, 3'd5, 1'b0, 11'd1, 1'b0, 10'h042},  // R3 reserved code
        '{10'h1FE, 3'd1, 1'b1, 11'd2, 1'b1, 10'h1FF}   // R5
    };

    function automatic logic [9:0] model(input logic [9:0] s, input int bl,
                                         input logic mix, input int k);
        logic [9:0] m;
        logic [9:0] lo;
        m  = 10'(bl - 1);
        lo = mix ? ((s ^ 10'(k)) & m) : ((s + 10'(k)) & m);
        return (s & ~m) | lo;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [9:0] s, input logic [2:0] len, input logic ilv);
        start_i = 1'b1; col_start_i = s; len_i = len; ilv_i = ilv;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_burst(input vec_t v);
        logic [9:0] e;
        issue(v.s, v.len, v.ilv);
        for (int k = 0; k < int'(v.bl); k++) begin
            e = model(v.s, int'(v.bl), v.mix, k);
            check(valid_o == 1'b1, "R2 valid", 32'(valid_o), 32'd1);
            if (k == 0)
                check(col_o == v.s, "R2 first column", 32'(col_o), 32'(v.s));
            check(col_o == e, v.mix ? "R5 column" : "R4 column", 32'(col_o), 32'(e));
            check(last_o == (k == int'(v.bl) - 1), "R6 last flag",
                  32'(last_o), 32'(k == int'(v.bl) - 1));
            if (k == int'(v.bl) - 1)
                check(col_o == v.lastc, "R11 R8 R3 final column", 32'(col_o), 32'(v.lastc));
            @(negedge clk);
        end
        check(valid_o == 1'b0, "R6 ends", 32'(valid_o), 32'd0);
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [9:0] e;
        rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0;
        col_start_i = '0; len_i = '0; ilv_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid_o == 1'b0, "R1 valid", 32'(valid_o), 32'd0);
        check(last_o == 1'b0, "R1 last", 32'(last_o), 32'd0);

        for (int i = 0; i < 10; i++) run_burst(VEC[i]);

        // R7: page mode across the top wrap, then R9 stop
        issue(10'h3FD, 3'd7, 1'b0);
        for (int k = 0; k < 6; k++) begin
            e = 10'(10'h3FD + k);
            check(valid_o && col_o == e, "R7 page column", 32'(col_o), 32'(e));
            check(last_o == 1'b0, "R7 no last", 32'(last_o), 32'd0);
            @(negedge clk);
        end
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        check(valid_o == 1'b0, "R9 stop page", 32'(valid_o), 32'd0);
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0, "R9 stays idle", 32'(valid_o), 32'd0);

        // R9: stop in the middle of an 8-beat burst
        issue(10'h010, 3'd3, 1'b0);
        @(negedge clk);
        check(col_o == 10'h011, "R4 second beat", 32'(col_o), 32'h011);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        check(valid_o == 1'b0, "R9 stop fixed", 32'(valid_o), 32'd0);
        check(last_o == 1'b0, "R9 no last after stop", 32'(last_o), 32'd0);

        // R10: restart mid-burst
        issue(10'h020, 3'd3, 1'b0);
        @(negedge clk);
        @(negedge clk);
        issue(10'h105, 3'd1, 1'b0);
        check(valid_o && col_o == 10'h105, "R10 restart column", 32'(col_o), 32'h105);
        check(last_o == 1'b0, "R10 restart beat0", 32'(last_o), 32'd0);
        @(negedge clk);
        check(col_o == 10'h104 && last_o, "R10 restart final", 32'(col_o), 32'h104);
        @(negedge clk);
        check(valid_o == 1'b0, "R10 restart ends", 32'(valid_o), 32'd0);

        // R10: start and stop together, the command wins
        start_i = 1'b1; stop_i = 1'b1; col_start_i = 10'h233; len_i = 3'd2; ilv_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0;
        check(valid_o && col_o == 10'h233, "R10 start beats stop", 32'(col_o), 32'h233);
        @(negedge clk);
        check(col_o == 10'h232, "R5 after tie", 32'(col_o), 32'h232);
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0, "R6 tie burst ends", 32'(valid_o), 32'd0);

        // R1: reset during a burst clears it
        issue(10'h300, 3'd7, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(valid_o == 1'b0, "R1 reset mid burst", 32'(valid_o), 32'd0);

        report();
    end

endmodule